// File: doc/BRIEF.md
# Synchronous 8-bit Serial I/O Controller

This block is a byte-wide shift-register port for a three-wire synchronous serial bus: one shift clock, one data-out line and one data-in line. A host loads the shift register while the port is idle, then raises a start pulse that sets the busy flag. The port exchanges eight bits, most significant bit first, and clears busy by itself. Afterwards the host reads the received byte from the same register. The host may also abort a transfer early, which leaves a partial shift in the register.

The port can be a bus master, where it divides the system clock down to a shift clock with a period of 2, 4 or 8 system cycles and drives that clock out. It can also be a slave, where an external shift clock is brought through a two-flop synchronizer and its edges are detected in the system clock domain. A phase bit picks which clock edge samples input and which edge launches output; the shift clock idles low in both cases. An optional interrupt flags each completed eight-bit transfer.

Top module: `sync_serial_port`

## Requirements
- R1: A one-cycle `busy_set` pulse while idle raises `busy` at the next clock edge. After eight bits have shifted, `busy` returns to 0 on its own. In master mode `busy` stays high for exactly 16 shift-clock half-periods.
- R2: A `busy_clr` pulse while busy drops `busy` at the next edge and forces `sck_out` low. Bits already shifted stay in `rd_data`, and no interrupt is raised.
- R3: When `irq_en` is 1 at the moment the eighth bit completes, `irq` rises in the same edge where `busy` falls, and it stays high until `irq_ack`. With `irq_en` at 0, no interrupt is raised.
- R4: In master mode `div_sel` sets the shift-clock period: 2'b00 gives 2 system cycles, 2'b01 gives 4, and 2'b10 or 2'b11 gives 8. The first half-period after start is always a full low phase.
- R5: `sck_out` is low whenever `busy` is 0.
- R6: With `phase_alt` at 0, `sdi` is sampled on the rising shift-clock edge. The register advances and `sdo_out` changes on the falling edge. `sdo_out` shows bit 7 of the register.
- R7: With `phase_alt` at 1, `sdi` is sampled on the falling edge and `sdo_out` changes on the rising edge, taking the register's current bit 7.
- R8: With `clk_oe` at 0 (slave), the port shifts on edges of `sck_in` after a two-flop synchronizer, in both phases, and exchanges a full byte with an external master.
- R9: In slave mode, `busy_set` is ignored while the synchronized `sck_in` is high.
- R10: `sdo_oe` follows `do_oe` (1 drives, 0 tri-states). `sck_oe` follows `clk_oe`, where 1 means master with the internal clock and 0 means slave with the external clock.
- R11: `wr_en` loads `wr_data` only while idle; writes during busy are ignored. `rd_data` returns the received byte with the first received bit in bit 7.
- R12: After reset, `busy`, `irq`, `sck_out`, `sdo_out` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (instruction) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load shift register from `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Shift register contents |
| busy_set | input | 1 | Start pulse |
| busy_clr | input | 1 | Abort pulse |
| busy | output | 1 | Transfer in progress |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the interrupt |
| irq | output | 1 | End-of-transfer interrupt |
| div_sel | input | 2 | Master clock divider select |
| phase_alt | input | 1 | 0 normal phase, 1 alternate phase |
| do_oe | input | 1 | Data-out pin enable |
| clk_oe | input | 1 | Clock pin enable / master select |
| sck_in | input | 1 | External shift clock (slave) |
| sck_out | output | 1 | Generated shift clock (master) |
| sck_oe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo_out | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data-out pin output enable |

## Verification
A wrong bit counter shows at `busy` at once: the flag drops earlier or later than 16 half-periods, and `rd_data` holds a byte shifted by the wrong amount. A wrong divider or phase state shows within the first shift-clock period. The clock either stretches or shrinks, or the partner device samples `sdo_out` one bit early, so the received byte comes out rotated. Wrong synchronizer or start-guard state in slave mode shows as a start accepted while `sck_in` is high, or as bits lost at the first external edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // Divider select codes
    typedef enum logic [1:0] {
        DIV_2  = 2'b00,
        DIV_4  = 2'b01,
        DIV_8A = 2'b10,
        DIV_8B = 2'b11
    } div_sel_e;

    // Shift clock edge events in the system clock domain
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    // Terminal value of the half-period counter (half period minus one)
    function automatic int unsigned half_lim(input logic [1:0] sel);
        case (div_sel_e'(sel))
            DIV_2:   return 0;
            DIV_4:   return 1;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/ssp_mclk.sv
module ssp_mclk
    import ssp_pkg::*;
#(
    parameter int unsigned HCNT_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       abort,
    input  logic [1:0] div_sel,
    output logic       sck,
    output sck_evt_t   evt
);

    typedef struct packed {
        logic [HCNT_W-1:0] cnt;
        logic              sck;
    } mclk_state_t;

    mclk_state_t st_d, st_q;
    logic [HCNT_W-1:0] lim;

    always_comb begin
        lim  = HCNT_W'(half_lim(div_sel));
        st_d = st_q;
        evt  = '0;
        if (!run || abort) begin
            st_d.cnt = '0;
            st_d.sck = 1'b0;
        end else if (st_q.cnt == lim) begin
            st_d.cnt = '0;
            st_d.sck = ~st_q.sck;
            evt.rise = ~st_q.sck;
            evt.fall = st_q.sck;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck = st_q.sck;

endmodule

// File: rtl/ssp_sync.sv
module ssp_sync
    import ssp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    output logic     level,
    output sck_evt_t evt
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                st_d       = st_q;
                st_d.chain = pin;
                st_d.prev  = st_q.chain[STAGES-1];
            end
        end else begin : g_many
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], pin};
                st_d.prev  = st_q.chain[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level    = st_q.chain[STAGES-1];
    assign evt.rise = st_q.chain[STAGES-1] & ~st_q.prev;
    assign evt.fall = ~st_q.chain[STAGES-1] & st_q.prev;

endmodule

// File: rtl/ssp_core.sv
module ssp_core
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy_set,
    input  logic              busy_clr,
    input  logic              irq_en,
    input  logic              irq_ack,
    input  logic              alt,
    input  logic              master,
    input  logic              slave_lvl,
    input  sck_evt_t          evt,
    input  logic              sdi,
    output logic              busy,
    output logic              irq,
    output logic [DATA_W-1:0] sreg,
    output logic              sdo
);

    localparam int unsigned BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [BCNT_W-1:0] cnt;
        logic              busy;
        logic              hold;
        logic              sdo;
        logic              irq;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        start_ok;
    logic        in_bit;

    always_comb begin
        st_d     = st_q;
        start_ok = busy_set & (master | ~slave_lvl);
        in_bit   = alt ? sdi : st_q.hold;

        if (irq_ack) st_d.irq = 1'b0;

        if (st_q.busy) begin
            if (busy_clr) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                if (evt.rise) begin
                    st_d.hold = sdi;
                    if (alt) st_d.sdo = st_q.sr[DATA_W-1];
                end
                if (evt.fall) begin
                    st_d.sr = {st_q.sr[DATA_W-2:0], in_bit};
                    if (st_q.cnt == LAST_BIT) begin
                        st_d.busy = 1'b0;
                        st_d.cnt  = '0;
                        if (irq_en) st_d.irq = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
        end else begin
            if (wr_en) st_d.sr = wr_data;
            if (start_ok) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign irq  = st_q.irq;
    assign sreg = st_q.sr;
    assign sdo  = alt ? st_q.sdo : st_q.sr[DATA_W-1];

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HCNT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy_set,
    input  logic              busy_clr,
    output logic              busy,
    input  logic              irq_en,
    input  logic              irq_ack,
    output logic              irq,
    input  logic [1:0]        div_sel,
    input  logic              phase_alt,
    input  logic              do_oe,
    input  logic              clk_oe,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo_out,
    output logic              sdo_oe
);

    sck_evt_t m_evt, s_evt, sel_evt;
    logic     s_lvl;
    logic     m_run;

    assign m_run   = busy & clk_oe;
    assign sel_evt = clk_oe ? m_evt : s_evt;

    ssp_mclk #(.HCNT_W(HCNT_W)) i_mclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (m_run),
        .abort   (busy_clr),
        .div_sel (div_sel),
        .sck     (sck_out),
        .evt     (m_evt)
    );

    ssp_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sck_in),
        .level (s_lvl),
        .evt   (s_evt)
    );

    ssp_core #(.DATA_W(DATA_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .busy_set  (busy_set),
        .busy_clr  (busy_clr),
        .irq_en    (irq_en),
        .irq_ack   (irq_ack),
        .alt       (phase_alt),
        .master    (clk_oe),
        .slave_lvl (s_lvl),
        .evt       (sel_evt),
        .sdi       (sdi),
        .busy      (busy),
        .irq       (irq),
        .sreg      (rd_data),
        .sdo       (sdo_out)
    );

    assign sck_oe = clk_oe;
    assign sdo_oe = do_oe;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_set,
    input logic              busy_clr,
    input logic              busy,
    input logic              irq_en,
    input logic              irq,
    input logic              clk_oe,
    input logic              sck_out,
    input logic [DATA_W-1:0] rd_data
);

    // R1
    start_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(busy_set));

    // R5
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_out);

    // R3
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(irq_en) && $fell(busy)));

    // R2
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_clr) |=> !busy);

    // R11
    reg_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe && $past(clk_oe) && $past(busy) && !$fell(sck_out)) |-> $stable(rd_data));

endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) i_ssp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_set (busy_set),
    .busy_clr (busy_clr),
    .busy     (busy),
    .irq_en   (irq_en),
    .irq      (irq),
    .clk_oe   (clk_oe),
    .sck_out  (sck_out),
    .rd_data  (rd_data)
);

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy_set = 1'b0;
    logic       busy_clr = 1'b0;
    logic       busy;
    logic       irq_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic [1:0] div_sel = '0;
    logic       phase_alt = 1'b0;
    logic       do_oe = 1'b0;
    logic       clk_oe = 1'b1;
    logic       sck_in = 1'b0;
    logic       sck_out;
    logic       sck_oe;
    logic       sdi = 1'b0;
    logic       sdo_out;
    logic       sdo_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sync_serial_port i_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .busy_set(busy_set), .busy_clr(busy_clr),
        .busy(busy), .irq_en(irq_en), .irq_ack(irq_ack), .irq(irq),
        .div_sel(div_sel), .phase_alt(phase_alt), .do_oe(do_oe),
        .clk_oe(clk_oe), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .sdi(sdi), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
    );

    function automatic int exp_busy_cycles(input logic [1:0] sel);
        return (sel == 2'b00) ? 16 : (sel == 2'b01) ? 32 : 64;
    endfunction

    function automatic logic [7:0] exp_partial(input logic [7:0] a, input int k);
        return (a << k) | 8'((1 << k) - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic master_xfer(input logic [7:0] a, input logic [7:0] b,
                               input logic [1:0] sel, input logic alt, input logic ien);
        logic [7:0] got;
        int cyc;
        got = '0;
        cyc = 0;
        @(negedge clk);
        clk_oe = 1'b1; div_sel = sel; phase_alt = alt; irq_en = ien;
        wr_en = 1'b1; wr_data = a; sdi = alt ? 1'b0 : b[7];
        @(negedge clk);
        wr_en = 1'b0; busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        fork
            begin
                while (busy) begin
                    cyc++;
                    @(negedge clk);
                end
            end
            begin
                for (int i = 0; i < 8; i++) begin
                    if (!alt) begin
                        @(posedge sck_out);
                        got[7-i] = sdo_out;
                        @(negedge sck_out);
                        if (i < 7) sdi = b[6-i];
                    end else begin
                        @(posedge sck_out);
                        sdi = b[7-i];
                        @(negedge sck_out);
                        got[7-i] = sdo_out;
                    end
                end
            end
        join
        @(negedge clk);
        // R1 R4: busy length in master mode
        chk("R4 busy cycles", cyc, exp_busy_cycles(sel));
        chk("R1 busy cleared", busy, 0);
        // R6 R7 R11: received byte MSB first, transmitted byte seen by partner
        chk(alt ? "R7 received" : "R6 received", rd_data, b);
        chk(alt ? "R7 sent" : "R6 sent", got, a);
        // R3
        chk("R3 irq", irq, ien);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R3 irq ack", irq, 0);
    endtask

    task automatic slave_xfer(input logic [7:0] a, input logic [7:0] b, input logic alt);
        logic [7:0] got;
        got = '0;
        @(negedge clk);
        clk_oe = 1'b0; phase_alt = alt; irq_en = 1'b1; sck_in = 1'b0;
        wr_en = 1'b1; wr_data = a;
        repeat (4) @(negedge clk);
        wr_en = 1'b0; busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        chk("R8 slave busy", busy, 1);
        for (int i = 0; i < 8; i++) begin
            if (!alt) begin
                sdi = b[7-i];
                repeat (8) @(negedge clk);
                got[7-i] = sdo_out;
                sck_in = 1'b1;
                repeat (8) @(negedge clk);
                sck_in = 1'b0;
            end else begin
                repeat (8) @(negedge clk);
                sck_in = 1'b1;
                sdi = b[7-i];
                repeat (8) @(negedge clk);
                got[7-i] = sdo_out;
                sck_in = 1'b0;
            end
        end
        repeat (6) @(negedge clk);
        chk("R8 slave done", busy, 0);
        chk("R8 slave received", rd_data, b);
        chk("R8 slave sent", got, a);
        chk("R3 slave irq", irq, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 busy", busy, 0);
        chk("R12 irq", irq, 0);
        chk("R12 sck_out", sck_out, 0);
        chk("R12 sdo_out", sdo_out, 0);
        chk("R12 rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: pin enables
        do_oe = 1'b1; clk_oe = 1'b1;
        #1 chk("R10 sdo_oe on", sdo_oe, 1);
        chk("R10 sck_oe master", sck_oe, 1);
        do_oe = 1'b0; clk_oe = 1'b0;
        #1 chk("R10 sdo_oe off", sdo_oe, 0);
        chk("R10 sck_oe slave", sck_oe, 0);
        do_oe = 1'b1; clk_oe = 1'b1;

        // Directed master transfers over every divider code and both phases
        master_xfer(8'hA5, 8'h3C, 2'b00, 1'b0, 1'b1);
        master_xfer(8'h81, 8'h7E, 2'b01, 1'b1, 1'b0);
        master_xfer(8'hFF, 8'h00, 2'b10, 1'b0, 1'b1);
        master_xfer(8'h00, 8'hFF, 2'b11, 1'b1, 1'b1);

        // R2 R11: abort after three bits, write during busy ignored
        @(negedge clk);
        clk_oe = 1'b1; div_sel = 2'b10; phase_alt = 1'b0; irq_en = 1'b1;
        wr_en = 1'b1; wr_data = 8'hC3; sdi = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge sck_out);
        @(negedge clk);
        busy_clr = 1'b1;
        @(negedge clk);
        busy_clr = 1'b0;
        chk("R2 abort busy", busy, 0);
        chk("R2 partial", rd_data, exp_partial(8'hC3, 3));
        repeat (20) @(negedge clk);
        chk("R5 sck idle after abort", sck_out, 0);
        chk("R2 no irq on abort", irq, 0);

        // R11: write while idle loads the register
        wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 idle write", rd_data, 8'h5A);

        // R9: slave start refused while external clock high
        clk_oe = 1'b0; sck_in = 1'b1;
        repeat (5) @(negedge clk);
        busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        @(negedge clk);
        chk("R9 start refused", busy, 0);
        sck_in = 1'b0;
        repeat (4) @(negedge clk);

        // R8: slave transfers in both phases
        slave_xfer(8'h96, 8'h69, 1'b0);
        slave_xfer(8'h1E, 8'hE1, 1'b1);

        // Random master and slave traffic
        for (int n = 0; n < 12; n++) begin
            master_xfer(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
        end
        for (int n = 0; n < 4; n++) begin
            slave_xfer(8'($urandom), 8'($urandom), 1'($urandom));
        end

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule